// File: doc/BRIEF.md
# Power-Managed Mode Sequencer

This block chooses the operating mode of a small processor whenever a sleep command retires. On that command it samples an idle-enable input and a 2-bit clock-select field. From these it picks one of three outcomes. Full sleep stops both the CPU and the peripheral clocks. An idle mode stops only the CPU clock. A run mode keeps the CPU clocked on the chosen source.

It drives the clock gates for the CPU and the peripherals. It also tells an external clock switcher which source to use, and gives a one-cycle pulse whenever that request changes. A watchdog time-out has a different meaning in different modes. While the CPU is halted it wakes the device. While the CPU runs it becomes a watchdog-reset request.

When the device wakes from an idle mode on a non-primary source, the CPU first runs on that same source. Once the primary oscillator reports ready, the block moves the request back to the primary clock. The block never writes the mode bits: they are inputs owned by software.

Top module: `pm_seq`

## Requirements
- R1: After a synchronous reset the block is in primary run: `cpu_clk_en`=1, `per_clk_en`=1, `src_req`=00, `pri_status`=1, `switch_pulse`=0, `wdt_rst_req`=0.
- R2: The source encoding is 00 = primary, 01 = secondary oscillator, and 10 or 11 = internal RC, which is reported on `src_req` as 10. A `sleep_cmd` taken while the CPU is clocked, with `idle_en`=0 and `clk_sel`=00, enters full sleep. Both clock enables are 0 from the next cycle.
- R3: A `sleep_cmd` taken while the CPU is clocked, with `idle_en`=1, enters idle on the encoded source. From the next cycle `cpu_clk_en`=0 and `per_clk_en`=1.
- R4: A `sleep_cmd` taken while the CPU is clocked, with `idle_en`=0 and a non-primary `clk_sel`, enters run mode on that source. `cpu_clk_en` stays 1.
- R5: While the CPU is clocked, `wdt_timeout` raises `wdt_rst_req` for exactly the next cycle. A `sleep_cmd` in the same cycle is discarded, so mode and source are unchanged.
- R6: In idle, `wake_evt` or `wdt_timeout` restarts the CPU on the idle source with no reset request. If that source is not primary, the CPU runs there until `pri_ready` is seen, and `src_req` then returns to 00.
- R7: In full sleep, `wake_evt` or `wdt_timeout` returns the block to primary run with no reset request.
- R8: `switch_pulse` is high for one cycle exactly when `src_req` has just changed.
- R9: Each new `sleep_cmd` samples the bits again. This also holds during the return-to-primary wait, where it cancels the return. A `sleep_cmd` in idle or full sleep has no effect.
- R10: `pri_status` is 1 exactly when `src_req` is 00 and the block is not in full sleep. Entering an RC or secondary mode clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_cmd | input | 1 | One-cycle strobe: a sleep instruction retired |
| idle_en | input | 1 | Selects idle instead of sleep/run |
| clk_sel | input | 2 | Requested clock source |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| wake_evt | input | 1 | Enabled wake event |
| pri_ready | input | 1 | Primary oscillator is stable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| src_req | output | 2 | Source requested from the clock switcher |
| switch_pulse | output | 1 | One-cycle trigger on a source change |
| wdt_rst_req | output | 1 | Watchdog-reset request |
| pri_status | output | 1 | Primary clock is driving the system |

## Verification
The collision of interest is a watchdog time-out that arrives in the same cycle as a sleep command while the CPU is clocked. By R5 the reset request must win and the sleep must leave no trace on the clock enables or on `src_req`. Directed cycles force this collision both in plain run and during the return-to-primary wait. Random traffic raises both strobes often enough that they coincide many more times. Every cycle is judged against a bench model that takes the watchdog branch first.

// File: rtl/pm_seq.sv
module pm_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_cmd,
  input  logic       idle_en,
  input  logic [1:0] clk_sel,
  input  logic       wdt_timeout,
  input  logic       wake_evt,
  input  logic       pri_ready,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [1:0] src_req,
  output logic       switch_pulse,
  output logic       wdt_rst_req,
  output logic       pri_status
);

  localparam logic [1:0] SRC_PRI = 2'b00;
  localparam logic [1:0] SRC_RC  = 2'b10;

  typedef enum logic [1:0] {ST_RUN, ST_IDLE, ST_SLEEP, ST_WAKE} st_t;

  st_t        st, st_n;
  logic [1:0] src, src_n;

  wire        running = (st == ST_RUN) || (st == ST_WAKE);
  wire [1:0]  sel_src = clk_sel[1] ? SRC_RC : clk_sel;

  always_comb begin
    st_n  = st;
    src_n = src;
    case (st)
      ST_RUN, ST_WAKE: begin
        if (wdt_timeout) begin
          st_n = st;
        end else if (sleep_cmd) begin
          src_n = sel_src;
          if (idle_en)                 st_n = ST_IDLE;
          else if (sel_src == SRC_PRI) st_n = ST_SLEEP;
          else                         st_n = ST_RUN;
        end else if (st == ST_WAKE && pri_ready) begin
          st_n  = ST_RUN;
          src_n = SRC_PRI;
        end
      end
      ST_IDLE:
        if (wake_evt || wdt_timeout)
          st_n = (src == SRC_PRI) ? ST_RUN : ST_WAKE;
      ST_SLEEP:
        if (wake_evt || wdt_timeout) begin
          st_n  = ST_RUN;
          src_n = SRC_PRI;
        end
      default: begin
        st_n  = ST_RUN;
        src_n = SRC_PRI;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_RUN;
      src          <= SRC_PRI;
      switch_pulse <= 1'b0;
      wdt_rst_req  <= 1'b0;
      pri_status   <= 1'b1;
    end else begin
      st           <= st_n;
      src          <= src_n;
      switch_pulse <= (src_n != src);
      wdt_rst_req  <= running && wdt_timeout;
      pri_status   <= (src_n == SRC_PRI) && (st_n != ST_SLEEP);
    end
  end

  assign cpu_clk_en = running;
  assign per_clk_en = (st != ST_SLEEP);
  assign src_req    = src;

  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_cmd && !wdt_timeout && !idle_en && clk_sel == 2'b00)
      |=> (!cpu_clk_en && !per_clk_en)); // R2

  AST_IDLE_GATES: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_cmd && !wdt_timeout && idle_en)
      |=> (!cpu_clk_en && per_clk_en)); // R3

  AST_RUN_KEEPS_CPU: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_cmd && !wdt_timeout && !idle_en && clk_sel != 2'b00)
      |=> cpu_clk_en); // R4

  AST_WDT_RESET: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && wdt_timeout) |=> (wdt_rst_req && cpu_clk_en && $stable(src_req))); // R5

  AST_WDT_WAKES: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && per_clk_en && wdt_timeout) |=> (cpu_clk_en && !wdt_rst_req)); // R6

  AST_HOLD_ALT: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && src_req != 2'b00 && !pri_ready && !sleep_cmd) |=> $stable(src_req)); // R6

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!per_clk_en && (wake_evt || wdt_timeout))
      |=> (cpu_clk_en && src_req == 2'b00 && !wdt_rst_req)); // R7

  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(src_req) |-> switch_pulse); // R8

  AST_PULSE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
    switch_pulse |-> !$stable(src_req)); // R8

  AST_HALTED_IGNORES_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && sleep_cmd && !wake_evt && !wdt_timeout)
      |=> (!cpu_clk_en && $stable(src_req))); // R9

  AST_PRI_STATUS: assert property (@(posedge clk) disable iff (rst)
    pri_status |-> (src_req == 2'b00 && per_clk_en)); // R10

endmodule

// File: tb/test_pm_seq.sv
module test_pm_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_cmd = 1'b0, idle_en = 1'b0, wdt_timeout = 1'b0, wake_evt = 1'b0, pri_ready = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic cpu_clk_en, per_clk_en, switch_pulse, wdt_rst_req, pri_status;
  logic [1:0] src_req;

  always #5 clk = ~clk;

  pm_seq i_pm_seq (
    .clk(clk), .rst(rst), .sleep_cmd(sleep_cmd), .idle_en(idle_en), .clk_sel(clk_sel),
    .wdt_timeout(wdt_timeout), .wake_evt(wake_evt), .pri_ready(pri_ready),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .src_req(src_req),
    .switch_pulse(switch_pulse), .wdt_rst_req(wdt_rst_req), .pri_status(pri_status)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model: 0 run, 1 idle, 2 sleep, 3 run-awaiting-primary
  int         m_mode;
  logic [1:0] m_src;
  logic       m_pulse, m_wdt;
  string      m_tag;

  function automatic logic [1:0] enc(input logic [1:0] s);
    return s[1] ? 2'b10 : s;
  endfunction

  function automatic logic [5:0] expect_vec();
    logic cpu, per, pri;
    cpu = (m_mode == 0) || (m_mode == 3);
    per = (m_mode != 2);
    pri = (m_src == 2'b00) && (m_mode != 2);
    return {cpu, per, m_src[1:0] == 2'b00 ? 1'b0 : 1'b1, m_pulse, m_wdt, pri};
  endfunction

  task automatic model_step();
    int         nm;
    logic [1:0] ns;
    logic       cpu;
    nm = m_mode; ns = m_src; cpu = (m_mode == 0) || (m_mode == 3);
    m_tag = "R8";
    if (cpu) begin
      if (wdt_timeout) m_tag = "R5";
      else if (sleep_cmd) begin
        ns = enc(clk_sel);
        if (idle_en) begin nm = 1; m_tag = "R3"; end
        else if (ns == 2'b00) begin nm = 2; m_tag = "R2"; end
        else begin nm = 0; m_tag = "R4"; end
        if (m_mode == 3) m_tag = "R9";
      end else if (m_mode == 3 && pri_ready) begin nm = 0; ns = 2'b00; m_tag = "R6"; end
    end else if (m_mode == 1) begin
      if (sleep_cmd) m_tag = "R9";
      if (wake_evt || wdt_timeout) begin nm = (m_src == 2'b00) ? 0 : 3; m_tag = "R6"; end
    end else begin
      if (sleep_cmd) m_tag = "R9";
      if (wake_evt || wdt_timeout) begin nm = 0; ns = 2'b00; m_tag = "R7"; end
    end
    m_pulse = (ns != m_src);
    m_wdt   = cpu && wdt_timeout;
    m_mode  = nm;
    m_src   = ns;
  endtask

  task automatic compare(input string tag);
    logic [5:0] e, a;
    logic       pri_e;
    checks++;
    pri_e = (m_src == 2'b00) && (m_mode != 2);
    e = expect_vec();
    a = {cpu_clk_en, per_clk_en, src_req != 2'b00, switch_pulse, wdt_rst_req, pri_status};
    if (a !== e || src_req !== m_src) begin
      errors++;
      $display("FAIL %s: cpu/per/alt/pulse/wdt/pri=%b src=%b expected %b src=%b", tag, a, src_req, e, m_src);
    end else if (pri_status !== pri_e) begin
      errors++;
      $display("FAIL R10: pri_status=%b expected %b", pri_status, pri_e);
    end
  endtask

  task automatic cyc(input logic s, input logic ie, input logic [1:0] cs,
                     input logic w, input logic wk, input logic pr);
    sleep_cmd = s; idle_en = ie; clk_sel = cs; wdt_timeout = w; wake_evt = wk; pri_ready = pr;
    model_step();
    @(negedge clk);
    compare(m_tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_mode = 0; m_src = 2'b00; m_pulse = 0; m_wdt = 0;
    compare("R1");

    // R5: watchdog and sleep collide in run; sleep discarded
    cyc(1, 1, 2'b01, 1, 0, 0);
    cyc(0, 0, 2'b00, 0, 0, 0);
    // R4: run on secondary
    cyc(1, 0, 2'b01, 0, 0, 0);
    // R3: idle on RC (11 reports as 10)
    cyc(1, 1, 2'b11, 0, 0, 0);
    // R9: sleep ignored while halted
    cyc(1, 0, 2'b00, 0, 0, 1);
    // R6: watchdog wakes idle, runs on RC while primary not ready
    cyc(0, 0, 2'b00, 1, 0, 0);
    cyc(0, 0, 2'b00, 0, 0, 0);
    // R5 collision during return wait
    cyc(1, 0, 2'b00, 1, 0, 1);
    // R6: primary ready, return to 00 with pulse
    cyc(0, 0, 2'b00, 0, 0, 1);
    cyc(0, 0, 2'b00, 0, 0, 1);
    // R2 then R7
    cyc(1, 0, 2'b00, 0, 0, 0);
    cyc(0, 0, 2'b00, 0, 0, 0);
    cyc(0, 0, 2'b00, 0, 1, 0);
    // R9: re-sample during return wait cancels return
    cyc(1, 1, 2'b01, 0, 0, 0);
    cyc(0, 0, 2'b00, 0, 1, 0);
    cyc(1, 0, 2'b10, 0, 0, 1);
    cyc(1, 1, 2'b00, 0, 0, 0);
    cyc(0, 0, 2'b00, 0, 1, 0);

    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) == 0, $urandom % 2, 2'($urandom % 4),
          ($urandom % 12) == 0, ($urandom % 6) == 0, ($urandom % 3) == 0);
    end

    // R1: reset from a non-primary mode
    cyc(1, 0, 2'b01, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_mode = 0; m_src = 2'b00; m_pulse = 0; m_wdt = 0;
    sleep_cmd = 0; wdt_timeout = 0; wake_evt = 0;
    compare("R1");
    finish_run();
  end
endmodule